// File: doc/BRIEF.md
# Supply-Status Strobe Guard

This block sits between a bus controller and the pins of an asynchronous non-volatile memory. It takes two status flags from external supply comparators. One says the supply is above the level below which writes must be blocked. The other says the supply is above the minimum operating level. From these flags it decides whether the controller's chip-enable and write-enable strobes reach the memory. Until the supply has been good for a full startup interval, both strobes are held at their inactive (high) level and the ready flag to the controller stays low.

Both flags pass through synchronisers before a small state machine uses them. The machine waits for both flags to be high, then runs a startup timer. It declares the memory ready only after the timer completes without interruption. Losing either flag at any time clears the timer and withdraws ready, and a complete fresh interval is then served. If ready is withdrawn while the controller holds chip enable low, the guard raises a one-cycle abort pulse so the controller knows the access did not complete.

The startup length is a parameter in clock cycles. By default it is derived from the clock frequency as 2 ms plus a 10 % margin.

Top module: `supply_write_guard`

## Requirements
- R1: While rst_ni is low, ready_o and abort_o are 0 and ce_n_o and we_n_o are 1.
- R2: Whenever ready_o is 0, ce_n_o and we_n_o are both 1, whatever the values of ce_n_i and we_n_i.
- R3: Both flags may become high while ready_o is 0, and then stay high. In that case ready_o rises at exactly the STARTUP_CYC+3rd rising edge, counting as edge 1 the first edge that samples both flags high.
- R4: While ready_o is 1, ce_n_o equals ce_n_i and we_n_o equals we_n_i in the same cycle.
- R5: When ready_o is 1 and either flag goes low, ready_o falls at the 3rd rising edge, counting as edge 1 the first edge that samples the flag low.
- R6: While wi_ok_i stays low, ready_o stays 0. Once both flags are high again, ready_o returns only after the full interval of R3.
- R7: If vmin_ok_i drops during the startup interval, ready_o does not rise, and the full interval of R3 applies once the flag returns. This holds at any point of the interval, up to and including its last cycle, where the drop takes priority over completion.
- R8: abort_o is 1 for exactly one cycle after the edge at which ready_o falls, if ce_n_i was 0 at that edge. Otherwise abort_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wi_ok_i | input | 1 | Supply above the write-block threshold |
| vmin_ok_i | input | 1 | Supply above the minimum operating level |
| ce_n_i | input | 1 | Chip enable from the controller, active low |
| we_n_i | input | 1 | Write enable from the controller, active low |
| ce_n_o | output | 1 | Chip enable to the memory, active low |
| we_n_o | output | 1 | Write enable to the memory, active low |
| ready_o | output | 1 | Memory may be accessed |
| abort_o | output | 1 | One-cycle pulse: ready withdrawn during an access |

## Verification
A timer that starts late or is not cleared shows up as a ready edge off the exact STARTUP_CYC+3 position. That position is measured from the first sampling of good flags. A stale timer after a drop gives a short interval, and the bench sweeps the drop point across every cycle of the interval to catch it. A state machine stuck in the wrong state shows up within three edges of a flag change, as a ready level that does not follow the flags. It also shows as a strobe that leaks through while ready is low. A wrong abort condition is seen in the single cycle after ready falls.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_WAIT    = 3'd1,
    ST_STARTUP = 3'd2,
    ST_READY   = 3'd3,
    ST_INHIBIT = 3'd4
  } guard_state_e;

  // 2.2 ms (2 ms + 10 %) expressed in cycles of a clock given in kHz
  function automatic int startup_cycles(input int clk_khz);
    return (clk_khz * 22) / 10;
  endfunction

endpackage

// File: rtl/guard_sync.sv
module guard_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);

  localparam int CNT_W = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
  import guard_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wi_s_i,
  input  logic         vmin_s_i,
  input  logic         done_i,
  input  logic         ce_n_i,
  output guard_state_e state_o,
  output logic         run_o,
  output logic         ready_o,
  output logic         abort_o
);

  guard_state_e state_q, state_d;
  logic         abort_q;
  logic         supply_ok;

  assign supply_ok = wi_s_i && vmin_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:   state_d = ST_WAIT;
      ST_WAIT: begin
        if (!wi_s_i)        state_d = ST_INHIBIT;
        else if (vmin_s_i)  state_d = ST_STARTUP;
      end
      ST_STARTUP: begin
        // a drop wins over completion in the same cycle
        if (!wi_s_i)        state_d = ST_INHIBIT;
        else if (!vmin_s_i) state_d = ST_WAIT;
        else if (done_i)    state_d = ST_READY;
      end
      ST_READY: begin
        if (!wi_s_i)        state_d = ST_INHIBIT;
        else if (!vmin_s_i) state_d = ST_WAIT;
      end
      ST_INHIBIT: begin
        if (supply_ok)      state_d = ST_STARTUP;
        else if (wi_s_i)    state_d = ST_WAIT;
      end
      default:              state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= (state_q == ST_READY) && (state_d != ST_READY) && !ce_n_i;
    end
  end

  assign state_o = state_q;
  assign run_o   = (state_q == ST_STARTUP);
  assign ready_o = (state_q == ST_READY);
  assign abort_o = abort_q;

endmodule

// File: rtl/supply_write_guard.sv
module supply_write_guard
  import guard_pkg::*;
#(
  parameter int CLK_KHZ     = 250_000,
  parameter int STARTUP_CYC = guard_pkg::startup_cycles(CLK_KHZ),
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wi_ok_i,
  input  logic vmin_ok_i,
  input  logic ce_n_i,
  input  logic we_n_i,
  output logic ce_n_o,
  output logic we_n_o,
  output logic ready_o,
  output logic abort_o
);

  logic [1:0]   flags_s;
  logic         wi_s, vmin_s;
  logic         run, done;
  guard_state_e state;

  guard_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({vmin_ok_i, wi_ok_i}),
    .q_o    (flags_s)
  );

  assign wi_s   = flags_s[0];
  assign vmin_s = flags_s[1];

  guard_timer #(.CYC(STARTUP_CYC)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .done_o (done)
  );

  guard_fsm fsm_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wi_s_i   (wi_s),
    .vmin_s_i (vmin_s),
    .done_i   (done),
    .ce_n_i   (ce_n_i),
    .state_o  (state),
    .run_o    (run),
    .ready_o  (ready_o),
    .abort_o  (abort_o)
  );

  // strobes pass only in the ready state, otherwise held inactive
  assign ce_n_o = ready_o ? ce_n_i : 1'b1;
  assign we_n_o = ready_o ? we_n_i : 1'b1;

endmodule

// File: rtl/supply_write_guard_chk.sv
module supply_write_guard_chk
  import guard_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ce_n_i,
  input logic         we_n_i,
  input logic         ce_n_o,
  input logic         we_n_o,
  input logic         ready_o,
  input logic         abort_o,
  input logic         wi_s_i,
  input logic         vmin_s_i,
  input guard_state_e state_i
);

  localparam int RUN_W = $clog2(STARTUP_CYC + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  // cycles for which both synchronised flags have been continuously high
  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_cnt <= '0;
    else if (!(wi_s_i && vmin_s_i)) run_cnt <= '0;
    else if (run_cnt != RUN_MAX)  run_cnt <= run_cnt + 1'b1;
  end

  assert_strobe_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (ce_n_o && we_n_o));

  assert_pass_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce_n_o == ce_n_i) && (we_n_o == we_n_i));

  assert_full_interval_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (run_cnt >= RUN_W'(STARTUP_CYC)));

  assert_ready_from_startup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> ($past(state_i) == ST_STARTUP));

  assert_drop_withdraws_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !(wi_s_i && vmin_s_i)) |=> !ready_o);

  assert_inhibit_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wi_s_i |=> !ready_o);

  assert_abort_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (!ready_o && $past(ready_o) && !$past(ce_n_i)));

  assert_abort_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  always_comb begin
    if (!rst_ni) assert_reset_R1: assert (!ready_o && !abort_o);
  end

endmodule

bind supply_write_guard supply_write_guard_chk #(.STARTUP_CYC(STARTUP_CYC)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_n_i   (ce_n_i),
  .we_n_i   (we_n_i),
  .ce_n_o   (ce_n_o),
  .we_n_o   (we_n_o),
  .ready_o  (ready_o),
  .abort_o  (abort_o),
  .wi_s_i   (wi_s),
  .vmin_s_i (vmin_s),
  .state_i  (state)
);

// File: tb/supply_write_guard_tb_top.sv
module supply_write_guard_tb_top;

  localparam int N = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wi_ok_i = 1'b0, vmin_ok_i = 1'b0;
  logic ce_n_i = 1'b1, we_n_i = 1'b1;
  logic ce_n_o, we_n_o, ready_o, abort_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  supply_write_guard #(.STARTUP_CYC(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wi_ok_i(wi_ok_i), .vmin_ok_i(vmin_ok_i),
    .ce_n_i(ce_n_i), .we_n_i(we_n_i), .ce_n_o(ce_n_o), .we_n_o(we_n_o),
    .ready_o(ready_o), .abort_o(abort_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // counts edges until ready_o reaches want; checks strobes stay high meanwhile
  task automatic edges_until(input logic want, input int limit, output int n);
    n = 0;
    while (ready_o !== want && n < limit) begin
      tick();
      n++;
      if (!ready_o && (ce_n_o !== 1'b1 || we_n_o !== 1'b1))
        check(0, "R2 strobe leak", {ce_n_o, we_n_o}, 3);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    #1;
    check(ready_o === 1'b0 && abort_o === 1'b0, "R1 ready/abort", {ready_o, abort_o}, 0);
    check(ce_n_o === 1'b1 && we_n_o === 1'b1, "R1 strobes", {ce_n_o, we_n_o}, 3);
    repeat (3) @(negedge clk_i);
    check(ready_o === 1'b0 && ce_n_o === 1'b1, "R1 held in reset", {ready_o, ce_n_o}, 1);
    rst_ni = 1'b1;

    // R2: every strobe combination blocked before supply is good
    for (int c = 0; c < 4; c++) begin
      {ce_n_i, we_n_i} = 2'(c);
      tick();
      check(ce_n_o === 1'b1 && we_n_o === 1'b1 && ready_o === 1'b0, "R2 blocked",
            {ce_n_o, we_n_o}, 3);
    end

    // R3: startup from power-up, strobes active low throughout
    ce_n_i = 1'b0; we_n_i = 1'b0;
    wi_ok_i = 1'b1; vmin_ok_i = 1'b1;
    edges_until(1'b1, 4 * N, n);
    check(n == N + 3, "R3 startup length", n, N + 3);

    // R4: pass-through sweep
    for (int c = 0; c < 4; c++) begin
      {ce_n_i, we_n_i} = 2'(c);
      #1;
      check(ce_n_o === ce_n_i && we_n_o === we_n_i, "R4 pass", {ce_n_o, we_n_o}, c);
      tick();
      check(abort_o === 1'b0, "R8 no abort in ready", abort_o, 0);
    end

    // R5/R6: brownout with idle bus
    ce_n_i = 1'b1; we_n_i = 1'b1;
    wi_ok_i = 1'b0;
    edges_until(1'b0, 10, n);
    check(n == 3, "R5 drop on wi", n, 3);
    check(abort_o === 1'b0, "R8 no abort when idle", abort_o, 0);
    for (int i = 0; i < 10; i++) begin
      tick();
      check(ready_o === 1'b0, "R6 held off during inhibit", ready_o, 0);
    end
    wi_ok_i = 1'b1;
    edges_until(1'b1, 4 * N, n);
    check(n == N + 3, "R6 fresh interval", n, N + 3);

    // R5/R8: minimum-supply loss during a read
    ce_n_i = 1'b0; we_n_i = 1'b1;
    vmin_ok_i = 1'b0;
    edges_until(1'b0, 10, n);
    check(n == 3, "R5 drop on vmin", n, 3);
    check(abort_o === 1'b1, "R8 abort raised", abort_o, 1);
    check(ce_n_o === 1'b1, "R2 ce forced after drop", ce_n_o, 1);
    tick();
    check(abort_o === 1'b0, "R8 abort one cycle", abort_o, 0);
    ce_n_i = 1'b1;
    vmin_ok_i = 1'b1;
    edges_until(1'b1, 4 * N, n);
    check(n == N + 3, "R3 after vmin loss", n, N + 3);

    // R8: write in progress at brownout
    ce_n_i = 1'b0; we_n_i = 1'b0;
    wi_ok_i = 1'b0;
    edges_until(1'b0, 10, n);
    check(abort_o === 1'b1 && we_n_o === 1'b1, "R8 abort on write", {abort_o, we_n_o}, 3);
    ce_n_i = 1'b1; we_n_i = 1'b1;
    wi_ok_i = 1'b1;
    edges_until(1'b1, 4 * N, n);
    check(n == N + 3, "R6 after write abort", n, N + 3);

    // R7: sweep the drop point over the whole interval, including its last cycle
    for (int d = 0; d <= N; d++) begin
      vmin_ok_i = 1'b0;
      edges_until(1'b0, 10, n);
      repeat (3) tick();
      vmin_ok_i = 1'b1;
      repeat (d) tick();
      vmin_ok_i = 1'b0;
      for (int i = 0; i < 5; i++) begin
        tick();
        check(ready_o === 1'b0, "R7 no ready after mid drop", ready_o, 0);
      end
      vmin_ok_i = 1'b1;
      edges_until(1'b1, 4 * N, n);
      check(n == N + 3, "R7 restart length", n, N + 3);
    end

    // R6: write-block flag lost mid-interval
    vmin_ok_i = 1'b0;
    edges_until(1'b0, 10, n);
    repeat (3) tick();
    vmin_ok_i = 1'b1;
    repeat (N / 2) tick();
    wi_ok_i = 1'b0;
    repeat (6) tick();
    check(ready_o === 1'b0, "R6 wi lost in startup", ready_o, 0);
    wi_ok_i = 1'b1;
    edges_until(1'b1, 4 * N, n);
    check(n == N + 3, "R6 restart after wi", n, N + 3);

    finish_run();
  end

endmodule